// File: doc/BRIEF.md
# Timer-Synchronized Pattern Output Generator

This block drives a bank of output pins in groups of four. Each group holds a staged "next value" that a processor or DMA engine loads through a small register write port. The staged value reaches the pins only when the period compare event of the timer channel chosen for that group arrives. Because of this, pin edges line up with timer events and do not vary with software latency. After every transfer the group pulses a request so that a DMA engine can load the following value before the next event.

Each group is run by a three-state controller: `ST_IDLE` (group disabled, output frozen), `ST_WAIT` (armed, waiting for a period event) and `ST_DEAD` (non-overlap mode only: falling bits are already applied and rising bits wait for the dead-time compare). The transitions are as follows. ST_IDLE→ST_WAIT happens when the enable bit is set. ST_WAIT→ST_DEAD happens on a period event in non-overlap mode when at least one bit rises. ST_DEAD→ST_WAIT happens on the dead-time event, or on a period event with no rising bits. ST_DEAD→ST_DEAD happens on a period event that again has rising bits. ST_WAIT/ST_DEAD→ST_IDLE happens when the enable bit is cleared. Every pin also has an inversion bit, applied after the output register. A stepper-motor phase sequencer is the typical use: a table of phase patterns is loaded, and a compare value sets the gap between a phase turning off and the next one turning on.

Top module: `tsync_pattern_gen`

## Requirements
- R1: After reset, all pins are 0, no transfer request is raised and no underrun flag is set.
- R2: A next-value write does not change the pins. A group's pins change only at a clock edge where that group's selected period compare input is high, and the new value is visible right after that edge.
- R3: Group g reacts only to period and dead-time inputs at bit index sel_g. Inputs on other channels and events for other groups leave group g's pins unchanged.
- R4: Each transfer raises that group's request bit for exactly one cycle, in the same cycle the new output first appears.
- R5: In non-overlap mode, bits that go 1→0 are applied at the period event. Bits that go 0→1 stay low until the next dead-time event on the selected channel. If no bit rises, the whole value is applied at the period event.
- R6: A disabled group keeps its last output value, ignores period events and raises no request. Re-enabling it arms it again.
- R7: A period event with no next-value write since the previous transfer transfers the same value again and sets that group's sticky underrun flag. Writing 1 to bit g of the clear register clears flag g.
- R8: Pin bit i equals output register bit i XOR inversion bit i. A change to the inversion register shows on the pins one edge after the write.
- R9: Register map: address g (0..3) holds next value g in bits [3:0]. Address 4 is the mode register, with enables in [3:0], non-overlap in [7:4] and a 2-bit channel select for group g in [9+2g:8+2g]. Address 5 holds the 16 inversion bits. Address 6 is underrun clear, bits [3:0]. Group g drives pins [4g+3:4g].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| trig_period_i | input | 4 | Period compare event per timer channel |
| trig_dead_i | input | 4 | Dead-time compare event per timer channel |
| pins_o | output | 16 | Pattern outputs after inversion |
| xfer_req_o | output | 4 | One-cycle transfer request per group |
| underrun_o | output | 4 | Sticky underrun flag per group |

## Verification
On every cycle, assertions check four things: the output register of a group holds when none of its selected events fire; a disabled group neither moves nor requests; a request follows each armed period event; and an armed transfer in non-overlap mode never raises a bit at the period event. They also check that underrun flags stay set until cleared. The bench scenarios are the only way to show the actual data values. These cover channel routing after a select change, the exact value that appears after the dead-time event across a long chain of pattern pairs, the repeat transfer on underrun, and how inversion combines with the output.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DEAD = 2'd2
    } grp_state_e;

endpackage

// File: rtl/tpg_regfile.sv
module tpg_regfile #(
    parameter int NG   = 4,
    parameter int GW   = 4,
    parameter int SELW = 2,
    parameter int AW   = 3,
    parameter int DW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [NG-1:0]        nd_we,
    output logic [NG-1:0]        ur_clr,
    output logic [NG-1:0]        en,
    output logic [NG-1:0]        nov,
    output logic [NG*SELW-1:0]   sel,
    output logic [NG*GW-1:0]     inv
);
    localparam int MODEW     = 2*NG + NG*SELW;
    localparam int PW        = NG*GW;
    localparam int ADDR_MODE = NG;
    localparam int ADDR_INV  = NG + 1;
    localparam int ADDR_CLR  = NG + 2;

    logic [MODEW-1:0] mode_q;
    logic [PW-1:0]    inv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            inv_q  <= '0;
        end else if (we) begin
            if (addr == AW'(ADDR_MODE)) mode_q <= wdata[MODEW-1:0];
            if (addr == AW'(ADDR_INV))  inv_q  <= wdata[PW-1:0];
        end
    end

    for (genvar g = 0; g < NG; g++) begin : g_dec
        assign nd_we[g]  = we && (addr == AW'(g));
        assign ur_clr[g] = we && (addr == AW'(ADDR_CLR)) && wdata[g];
    end

    assign en  = mode_q[NG-1:0];
    assign nov = mode_q[2*NG-1:NG];
    assign sel = mode_q[2*NG +: NG*SELW];
    assign inv = inv_q;

endmodule

// File: rtl/tpg_group.sv
module tpg_group
    import tpg_pkg::*;
#(
    parameter int GW    = 4,
    parameter int NTRIG = 4,
    parameter int SELW  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nd_we,
    input  logic [GW-1:0]    nd_wdata,
    input  logic             en,
    input  logic             nov,
    input  logic [SELW-1:0]  sel,
    input  logic [NTRIG-1:0] trig_period,
    input  logic [NTRIG-1:0] trig_dead,
    input  logic             ur_clr,
    output logic [GW-1:0]    out_o,
    output logic             req_o,
    output logic             underrun_o
);
    grp_state_e state_q, state_d;

    logic [GW-1:0] nd_q, out_q, pend_q;
    logic          fresh_q, req_q, ur_q;
    logic          hit_b, hit_a, xfer, rising, dead_done;

    assign hit_b     = trig_period[sel];
    assign hit_a     = trig_dead[sel];
    assign rising    = |(nd_q & ~out_q);
    assign xfer      = en && (state_q != ST_IDLE) && hit_b;
    assign dead_done = en && (state_q == ST_DEAD) && !hit_b && hit_a;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (en) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!en)                        state_d = ST_IDLE;
                else if (hit_b && nov && rising) state_d = ST_DEAD;
            end
            ST_DEAD: begin
                if (!en)        state_d = ST_IDLE;
                else if (hit_b) state_d = (nov && rising) ? ST_DEAD : ST_WAIT;
                else if (hit_a) state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nd_q    <= '0;
            out_q   <= '0;
            pend_q  <= '0;
            fresh_q <= 1'b0;
            req_q   <= 1'b0;
            ur_q    <= 1'b0;
        end else begin
            req_q <= xfer;
            if (nd_we) nd_q <= nd_wdata;
            if (nd_we)     fresh_q <= 1'b1;
            else if (xfer) fresh_q <= 1'b0;
            if (xfer && !fresh_q) ur_q <= 1'b1;
            else if (ur_clr)      ur_q <= 1'b0;
            if (xfer) begin
                pend_q <= nd_q;
                out_q  <= (nov && rising) ? (out_q & nd_q) : nd_q;
            end else if (dead_done) begin
                out_q <= pend_q;
            end
        end
    end

    assign out_o      = out_q;
    assign req_o      = req_q;
    assign underrun_o = ur_q;

    AST_HOLD_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_b && !hit_a) |=> $stable(out_q)); // R2
    AST_REQ_FOLLOWS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q != ST_IDLE && hit_b) |=> req_o); // R4
    AST_NOV_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && nov && state_q == ST_WAIT && hit_b) |=> ((out_q & ~$past(out_q)) == '0)); // R5
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(out_q) && !req_o)); // R6
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_q && !ur_clr) |=> ur_q); // R7

endmodule

// File: rtl/tsync_pattern_gen.sv
module tsync_pattern_gen #(
    parameter int NGROUPS = 4,
    parameter int GW      = 4,
    parameter int NTRIG   = 4,
    localparam int SELW   = (NTRIG > 1) ? $clog2(NTRIG) : 1,
    localparam int PW     = NGROUPS * GW,
    localparam int MODEW  = 2*NGROUPS + NGROUPS*SELW,
    localparam int DW     = (MODEW > PW) ? MODEW : PW,
    localparam int AW     = $clog2(NGROUPS + 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    input  logic [NTRIG-1:0]   trig_period_i,
    input  logic [NTRIG-1:0]   trig_dead_i,
    output logic [PW-1:0]      pins_o,
    output logic [NGROUPS-1:0] xfer_req_o,
    output logic [NGROUPS-1:0] underrun_o
);
    logic [NGROUPS-1:0]      nd_we_w, ur_clr_w, en_w, nov_w;
    logic [NGROUPS*SELW-1:0] sel_w;
    logic [PW-1:0]           inv_w, out_w;

    tpg_regfile #(
        .NG(NGROUPS), .GW(GW), .SELW(SELW), .AW(AW), .DW(DW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .nd_we(nd_we_w), .ur_clr(ur_clr_w), .en(en_w), .nov(nov_w),
        .sel(sel_w), .inv(inv_w)
    );

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        tpg_group #(.GW(GW), .NTRIG(NTRIG), .SELW(SELW)) grp_i (
            .clk(clk), .rst_n(rst_n),
            .nd_we(nd_we_w[g]), .nd_wdata(reg_wdata[GW-1:0]),
            .en(en_w[g]), .nov(nov_w[g]), .sel(sel_w[g*SELW +: SELW]),
            .trig_period(trig_period_i), .trig_dead(trig_dead_i),
            .ur_clr(ur_clr_w[g]),
            .out_o(out_w[g*GW +: GW]), .req_o(xfer_req_o[g]),
            .underrun_o(underrun_o[g])
        );
    end

    assign pins_o = out_w ^ inv_w;

endmodule

// File: tb/tsync_pattern_gen_tb_top.sv
module tsync_pattern_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [3:0]  trig_period_i = '0;
    logic [3:0]  trig_dead_i = '0;
    logic [15:0] pins_o;
    logic [3:0]  xfer_req_o, underrun_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [3:0]  exp_out [4];
    logic [15:0] inv_m = '0;
    logic [7:0]  ident_sel = 8'b11_10_01_00;

    always #10 clk = ~clk;

    tsync_pattern_gen dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .trig_period_i(trig_period_i),
        .trig_dead_i(trig_dead_i), .pins_o(pins_o),
        .xfer_req_o(xfer_req_o), .underrun_o(underrun_o)
    );

    function automatic logic [15:0] exp_pins();
        return {exp_out[3], exp_out[2], exp_out[1], exp_out[0]} ^ inv_m;
    endfunction

    function automatic logic [15:0] mk_mode(logic [3:0] en, logic [3:0] nov, logic [7:0] sel);
        return {sel, nov, en};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic chk_pins(input string req);
        check(pins_o == exp_pins(), req, 32'(pins_o), 32'(exp_pins()));
    endtask

    task automatic chk_req(input string req, input logic [3:0] e);
        check(xfer_req_o == e, req, 32'(xfer_req_o), 32'(e));
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] b, input logic [3:0] a);
        trig_period_i = b; trig_dead_i = a;
        @(negedge clk);
        trig_period_i = '0; trig_dead_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [3:0] nd_v [4];
        for (int g = 0; g < 4; g++) exp_out[g] = '0;
        idle(2);
        // R1: reset state
        chk_pins("R1");
        chk_req("R1", 4'b0000);
        check(underrun_o == 0, "R1", 32'(underrun_o), 32'd0);
        rst_n = 1'b1;
        idle(1);

        // R9: enable all groups, identity channel select
        wr(3'd4, mk_mode(4'hF, 4'h0, ident_sel));
        idle(2);

        // R2, R3, R4: sweep values on all groups
        for (int v = 0; v < 16; v++) begin
            for (int g = 0; g < 4; g++) begin
                nd_v[g] = 4'((v + 5*g) & 15);
                wr(3'(g), 16'(nd_v[g]));
            end
            chk_pins("R2");
            pulse(4'b0001, 4'b0000);
            exp_out[0] = nd_v[0];
            chk_pins("R3");
            chk_req("R4", 4'b0001);
            idle(1);
            chk_req("R4", 4'b0000);
            pulse(4'b1110, 4'b0000);
            for (int g = 1; g < 4; g++) exp_out[g] = nd_v[g];
            chk_pins("R2");
            chk_req("R4", 4'b1110);
        end

        // R3: reroute group 0 to channel 3
        wr(3'd4, mk_mode(4'hF, 4'h0, 8'b11_10_01_11));
        wr(3'd0, 16'h9);
        wr(3'd3, 16'h6);
        pulse(4'b0001, 4'b0000);
        chk_pins("R3");
        chk_req("R3", 4'b0000);
        pulse(4'b1000, 4'b0000);
        exp_out[0] = 4'h9; exp_out[3] = 4'h6;
        chk_pins("R3");
        chk_req("R3", 4'b1001);

        // R7: underrun on group 1
        wr(3'd4, mk_mode(4'hF, 4'h0, ident_sel));
        wr(3'd6, 16'hF);
        check(underrun_o == 0, "R7", 32'(underrun_o), 32'd0);
        pulse(4'b0010, 4'b0000);
        chk_pins("R7");
        chk_req("R7", 4'b0010);
        check(underrun_o == 4'b0010, "R7", 32'(underrun_o), 32'h2);
        idle(3);
        check(underrun_o == 4'b0010, "R7", 32'(underrun_o), 32'h2);
        wr(3'd6, 16'h2);
        check(underrun_o == 0, "R7", 32'(underrun_o), 32'd0);

        // R5: non-overlap on group 2 over a chain of pattern pairs
        wr(3'd4, mk_mode(4'hF, 4'b0100, ident_sel));
        idle(1);
        for (int i = 0; i < 256; i++) begin
            logic [3:0] to_v, from_v;
            to_v   = 4'((i*7 + (i >> 4)) & 15);
            from_v = exp_out[2];
            wr(3'd2, 16'(to_v));
            pulse(4'b0100, 4'b0000);
            if ((to_v & ~from_v) != 0) begin
                exp_out[2] = from_v & to_v;
                chk_pins("R5");
                chk_req("R5", 4'b0100);
                idle(2);
                chk_pins("R5");
                pulse(4'b0000, 4'b1011);
                chk_pins("R3");
                pulse(4'b0000, 4'b0100);
                exp_out[2] = to_v;
                chk_pins("R5");
            end else begin
                exp_out[2] = to_v;
                chk_pins("R5");
                pulse(4'b0000, 4'b0100);
                chk_pins("R5");
            end
        end

        // R6: disable group 1
        wr(3'd4, mk_mode(4'b1101, 4'b0100, ident_sel));
        idle(2);
        wr(3'd1, 16'hC);
        pulse(4'b0010, 4'b0000);
        chk_pins("R6");
        chk_req("R6", 4'b0000);
        wr(3'd4, mk_mode(4'hF, 4'b0100, ident_sel));
        idle(2);
        pulse(4'b0010, 4'b0000);
        exp_out[1] = 4'hC;
        chk_pins("R6");
        chk_req("R6", 4'b0010);

        // R8: inversion
        wr(3'd5, 16'hA5C3);
        inv_m = 16'hA5C3;
        chk_pins("R8");
        wr(3'd0, 16'h3);
        pulse(4'b0001, 4'b0000);
        exp_out[0] = 4'h3;
        chk_pins("R8");
        wr(3'd5, 16'h0);
        inv_m = 16'h0;
        chk_pins("R8");

        finish_run();
    end
endmodule